// File: doc/BRIEF.md
# Keyboard Poll Sequencer for a Command-Byte USB Host Controller

This block brings a USB host controller chip into host mode with frame generation. It then polls a boot-protocol keyboard on that host. It does not shift serial bits itself. It drives a separate command engine through a request port and consumes that engine's response byte stream. Each request names one opcode, an optional parameter byte and the number of response bytes the engine should clock back. The engine pulses a done strobe once the transfer has closed.

After initialisation, every poll tick starts one poll. The poll sends an IN token command and then waits for the controller's interrupt event. It reads the status byte, which also clears the interrupt on the controller. On success it drains the receive buffer. A valid 8-byte report is presented on a ready/valid output as a modifier byte and six key codes. A NAK status is the normal "nothing new" answer and the sequencer simply goes idle. A disconnect status drops any pending report and restarts initialisation. Translating key codes into key events is left to the consumer.

The states, in order of use, are: `ST_BOOT` (reset, leaves after one cycle), `ST_CHK_REQ`/`ST_CHK_WAIT` (loopback check), `ST_RST_REQ`/`ST_RST_WAIT` (soft reset), `ST_MODE_REQ`/`ST_MODE_WAIT` (host-with-frames mode), `ST_IDLE`, `ST_TOK_REQ`/`ST_TOK_WAIT` (IN token), `ST_INT_WAIT`, `ST_STAT_REQ`/`ST_STAT_WAIT` (status read) and `ST_RD_REQ`/`ST_RD_WAIT` (buffer drain). Every `*_REQ` state moves to its `*_WAIT` state when the engine accepts the request. The transitions are:
- Loopback good goes to soft reset. Loopback bad repeats the check.
- Mode done goes to idle.
- Tick in idle goes to token. Token done goes to interrupt wait.
- Interrupt wait goes to status on an interrupt, or to idle on timeout.
- After the status read: success goes to drain, disconnect goes to the loopback check, and any other status goes to idle.
- Drain done goes to idle.

Top module: `kbd_poll_seq`

## Requirements
- R1: After reset the request port issues, in this order: opcode 0x06 with parameter 0x55 and 1 response byte, then opcode 0x05 with no parameter and 0 response bytes, then opcode 0x15 with parameter 0x06 and 0 response bytes. The sequencer is then idle. No other opcodes than 0x06, 0x05, 0x15, 0x45, 0x22 and 0x27 are ever requested.
- R2: If the loopback response byte is not 0xAA (the bitwise inverse of 0x55), the loopback request is repeated instead of moving on to the soft reset.
- R3: Once `req_valid` is raised, it and all request fields stay unchanged until the cycle in which `req_ready` is high. Each command produces exactly one accepted request.
- R4: A `poll_tick` seen while idle issues opcode 0x45 with parameter 0x19 and 0 response bytes. A tick seen in any other state is ignored and issues nothing.
- R5: After the token's done strobe, nothing is requested until an interrupt event. An interrupt event that arrives while the token transfer is still open counts. The next request is opcode 0x22 with 1 response byte.
- R6: If no interrupt has arrived within `TMO_CYCLES` cycles after the token's done strobe, the sequencer returns to idle without a status read. An interrupt in the last cycle of that window wins over the timeout. An interrupt after the window is ignored.
- R7: Status 0x14 (success) is followed by opcode 0x27 with 9 response bytes. Status 0x2F (NAK) returns to idle without changing the report output or the error count.
- R8: The first byte read back by 0x27 is a length. If it is 8, the next 8 bytes become the report: `rpt_mod` is report byte 0, and key slot k (bits 8k+7:8k of `rpt_keys`) is report byte k+2. `rpt_valid` rises the cycle after the done strobe. Any other length discards the data and increments the saturating `bad_len_cnt` by one.
- R9: `rpt_valid` stays high until `rpt_ready` is seen with it. A newer report overwrites a pending one. If a report is accepted in the same cycle a new one completes, `rpt_valid` stays high with the new data.
- R10: Status 0x16 (disconnect) clears `rpt_valid` and restarts initialisation with the loopback request.
- R11: While reset is held, `req_valid` and `rpt_valid` are low and `bad_len_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Command request offered to the engine |
| req_ready | input | 1 | Engine accepts the request |
| req_op | output | 8 | Opcode byte |
| req_arg | output | 8 | Parameter byte (zero when unused) |
| req_arg_en | output | 1 | Parameter byte is sent |
| req_rd_len | output | 4 | Number of response bytes to clock back |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_data | input | 8 | Response byte |
| eng_done | input | 1 | Engine finished the accepted transfer, one cycle after its last byte |
| int_evt | input | 1 | One-cycle interrupt event from the controller |
| poll_tick | input | 1 | Frame-interval polling tick |
| rpt_valid | output | 1 | Report available |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_mod | output | 8 | Modifier bitmap |
| rpt_keys | output | 48 | Six key codes, slot k at bits 8k+7:8k |
| bad_len_cnt | output | ERR_W | Saturating count of discarded reports |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the interrupt event and the timeout expiry. The bench places the interrupt exactly in the last cycle of the window and expects a status read. It then places it one cycle later and expects silence until the next tick brings a fresh token. The second pair is the consumer taking a report while the engine's done strobe completes the next one. The bench drives `rpt_ready` in the done cycle and expects `rpt_valid` to stay high and carry the new bytes. Its per-cycle report model judges both outcomes.

// File: rtl/kbd_poll_pkg.sv
package kbd_poll_pkg;

    localparam logic [7:0] OP_CHECK  = 8'h06;
    localparam logic [7:0] OP_RESET  = 8'h05;
    localparam logic [7:0] OP_MODE   = 8'h15;
    localparam logic [7:0] OP_TOKEN  = 8'h45;
    localparam logic [7:0] OP_STATUS = 8'h22;
    localparam logic [7:0] OP_READ   = 8'h27;

    localparam int RPT_BYTES = 8;
    localparam int KEY_SLOTS = 6;
    localparam int KEY_BASE  = 2;
    localparam int RDLEN_W   = 4;
    localparam int RD_TOTAL  = RPT_BYTES + 1;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_CHK_REQ,
        ST_CHK_WAIT,
        ST_RST_REQ,
        ST_RST_WAIT,
        ST_MODE_REQ,
        ST_MODE_WAIT,
        ST_IDLE,
        ST_TOK_REQ,
        ST_TOK_WAIT,
        ST_INT_WAIT,
        ST_STAT_REQ,
        ST_STAT_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [7:0]         op;
        logic [7:0]         arg;
        logic               arg_en;
        logic [RDLEN_W-1:0] rd_len;
    } cmd_t;

endpackage

// File: rtl/kbd_tmo_timer.sv
module kbd_tmo_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/kbd_rpt_capture.sv
module kbd_rpt_capture import kbd_poll_pkg::*; #(
    parameter int ERR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   byte_en,
    input  logic [7:0]             byte_in,
    input  logic                   finish,
    input  logic                   flush,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [7:0]             out_mod,
    output logic [8*KEY_SLOTS-1:0] out_keys,
    output logic [ERR_W-1:0]       bad_cnt,
    output logic                   commit
);
    localparam int IDX_W = $clog2(RD_TOTAL + 2);
    localparam int BUF_W = $clog2(RPT_BYTES);

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       len_q;
    logic [7:0]       buf_q [RPT_BYTES];
    logic [7:0]       rpt_q [RPT_BYTES];
    logic             reject;

    assign commit = finish && (len_q == 8'(RPT_BYTES)) && (idx_q == IDX_W'(RD_TOTAL));
    assign reject = finish && !commit;

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (byte_en) begin
            if (idx_q == '0) begin
                len_q <= byte_in;
            end else if (idx_q <= IDX_W'(RPT_BYTES)) begin
                buf_q[BUF_W'(idx_q - 1'b1)] <= byte_in;
            end
            if (idx_q != '1) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            bad_cnt   <= '0;
            for (int i = 0; i < RPT_BYTES; i++) rpt_q[i] <= '0;
        end else begin
            if (flush) begin
                out_valid <= 1'b0;
            end else if (commit) begin
                out_valid <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (commit) begin
                for (int i = 0; i < RPT_BYTES; i++) rpt_q[i] <= buf_q[i];
            end
            if (reject && (bad_cnt != '1)) begin
                bad_cnt <= bad_cnt + 1'b1;
            end
        end
    end

    assign out_mod = rpt_q[0];

    for (genvar k = 0; k < KEY_SLOTS; k++) begin : g_key
        assign out_keys[8*k +: 8] = rpt_q[k + KEY_BASE];
    end
endmodule

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm import kbd_poll_pkg::*; #(
    parameter logic [7:0] TOKEN_ARG   = 8'h19,
    parameter logic [7:0] CHK_PATTERN = 8'h55,
    parameter logic [7:0] MODE_SEL    = 8'h06,
    parameter logic [7:0] ST_SUCCESS  = 8'h14,
    parameter logic [7:0] ST_DISC     = 8'h16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_ready,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    input  logic       eng_done,
    input  logic       int_evt,
    input  logic       poll_tick,
    input  logic       tmo_expire,
    output logic       req_valid,
    output cmd_t       cmd,
    output logic       cap_start,
    output logic       cap_en,
    output logic       cap_end,
    output logic       flush,
    output logic       tmo_run
);
    seq_state_e state_q, state_d;
    logic [7:0] stat_q;
    logic       int_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q     <= '0;
            int_seen_q <= 1'b0;
        end else begin
            if (state_q == ST_CHK_REQ || state_q == ST_STAT_REQ) begin
                stat_q <= '0;
            end else if (rsp_valid && (state_q == ST_CHK_WAIT || state_q == ST_STAT_WAIT)) begin
                stat_q <= rsp_data;
            end
            if (state_q == ST_TOK_REQ) begin
                int_seen_q <= 1'b0;
            end else if (int_evt && state_q == ST_TOK_WAIT) begin
                int_seen_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:      state_d = ST_CHK_REQ;
            ST_CHK_REQ:   if (req_ready) state_d = ST_CHK_WAIT;
            ST_CHK_WAIT:  if (eng_done)  state_d = (stat_q == ~CHK_PATTERN) ? ST_RST_REQ : ST_CHK_REQ;
            ST_RST_REQ:   if (req_ready) state_d = ST_RST_WAIT;
            ST_RST_WAIT:  if (eng_done)  state_d = ST_MODE_REQ;
            ST_MODE_REQ:  if (req_ready) state_d = ST_MODE_WAIT;
            ST_MODE_WAIT: if (eng_done)  state_d = ST_IDLE;
            ST_IDLE:      if (poll_tick) state_d = ST_TOK_REQ;
            ST_TOK_REQ:   if (req_ready) state_d = ST_TOK_WAIT;
            ST_TOK_WAIT:  if (eng_done)  state_d = ST_INT_WAIT;
            ST_INT_WAIT: begin
                if (int_evt || int_seen_q) state_d = ST_STAT_REQ;
                else if (tmo_expire)       state_d = ST_IDLE;
            end
            ST_STAT_REQ:  if (req_ready) state_d = ST_STAT_WAIT;
            ST_STAT_WAIT: begin
                if (eng_done) begin
                    if (stat_q == ST_SUCCESS)   state_d = ST_RD_REQ;
                    else if (stat_q == ST_DISC) state_d = ST_CHK_REQ;
                    else                        state_d = ST_IDLE;
                end
            end
            ST_RD_REQ:    if (req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT:   if (eng_done)  state_d = ST_IDLE;
            default:      state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        cmd       = '0;
        unique case (state_q)
            ST_CHK_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_CHECK, arg: CHK_PATTERN, arg_en: 1'b1, rd_len: RDLEN_W'(1)};
            end
            ST_RST_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_RESET, arg: 8'h00, arg_en: 1'b0, rd_len: RDLEN_W'(0)};
            end
            ST_MODE_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_MODE, arg: MODE_SEL, arg_en: 1'b1, rd_len: RDLEN_W'(0)};
            end
            ST_TOK_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_TOKEN, arg: TOKEN_ARG, arg_en: 1'b1, rd_len: RDLEN_W'(0)};
            end
            ST_STAT_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_STATUS, arg: 8'h00, arg_en: 1'b0, rd_len: RDLEN_W'(1)};
            end
            ST_RD_REQ: begin
                req_valid = 1'b1;
                cmd = '{op: OP_READ, arg: 8'h00, arg_en: 1'b0, rd_len: RDLEN_W'(RD_TOTAL)};
            end
            default: ;
        endcase
        cap_start = (state_q == ST_RD_REQ);
        cap_en    = (state_q == ST_RD_WAIT) && rsp_valid;
        cap_end   = (state_q == ST_RD_WAIT) && eng_done;
        flush     = (state_q == ST_STAT_WAIT) && eng_done && (stat_q == ST_DISC);
        tmo_run   = (state_q == ST_INT_WAIT);
    end
endmodule

// File: rtl/kbd_poll_seq.sv
module kbd_poll_seq import kbd_poll_pkg::*; #(
    parameter int         TMO_CYCLES  = 1000,
    parameter int         ERR_W       = 8,
    parameter logic [7:0] TOKEN_ARG   = 8'h19,
    parameter logic [7:0] CHK_PATTERN = 8'h55,
    parameter logic [7:0] MODE_SEL    = 8'h06,
    parameter logic [7:0] ST_SUCCESS  = 8'h14,
    parameter logic [7:0] ST_DISC     = 8'h16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [7:0]             req_op,
    output logic [7:0]             req_arg,
    output logic                   req_arg_en,
    output logic [3:0]             req_rd_len,
    input  logic                   rsp_valid,
    input  logic [7:0]             rsp_data,
    input  logic                   eng_done,
    input  logic                   int_evt,
    input  logic                   poll_tick,
    output logic                   rpt_valid,
    input  logic                   rpt_ready,
    output logic [7:0]             rpt_mod,
    output logic [47:0]            rpt_keys,
    output logic [ERR_W-1:0]       bad_len_cnt
);
    cmd_t cmd;
    logic cap_start, cap_en, cap_end, cap_flush, cap_commit;
    logic tmo_run, tmo_expire;

    kbd_seq_fsm #(
        .TOKEN_ARG  (TOKEN_ARG),
        .CHK_PATTERN(CHK_PATTERN),
        .MODE_SEL   (MODE_SEL),
        .ST_SUCCESS (ST_SUCCESS),
        .ST_DISC    (ST_DISC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .eng_done  (eng_done),
        .int_evt   (int_evt),
        .poll_tick (poll_tick),
        .tmo_expire(tmo_expire),
        .req_valid (req_valid),
        .cmd       (cmd),
        .cap_start (cap_start),
        .cap_en    (cap_en),
        .cap_end   (cap_end),
        .flush     (cap_flush),
        .tmo_run   (tmo_run)
    );

    kbd_tmo_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmo_run),
        .expire(tmo_expire)
    );

    kbd_rpt_capture #(.ERR_W(ERR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cap_start),
        .byte_en  (cap_en),
        .byte_in  (rsp_data),
        .finish   (cap_end),
        .flush    (cap_flush),
        .out_ready(rpt_ready),
        .out_valid(rpt_valid),
        .out_mod  (rpt_mod),
        .out_keys (rpt_keys),
        .bad_cnt  (bad_len_cnt),
        .commit   (cap_commit)
    );

    assign req_op     = cmd.op;
    assign req_arg    = cmd.arg;
    assign req_arg_en = cmd.arg_en;
    assign req_rd_len = cmd.rd_len;
endmodule

// File: rtl/kbd_poll_chk.sv
module kbd_poll_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [7:0]       req_op,
    input logic [7:0]       req_arg,
    input logic             req_arg_en,
    input logic [3:0]       req_rd_len,
    input logic             rpt_valid,
    input logic             rpt_ready,
    input logic [7:0]       rpt_mod,
    input logic [47:0]      rpt_keys,
    input logic [ERR_W-1:0] bad_len_cnt,
    input logic             flush,
    input logic             commit
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_arg)
                                    && $stable(req_arg_en) && $stable(req_rd_len)); // R3

    AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op inside {8'h06, 8'h05, 8'h15, 8'h45, 8'h22, 8'h27})); // R1

    AST_DRAIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op == 8'h27) |-> (req_rd_len == 4'd9) && !req_arg_en); // R7

    AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !rpt_ready && !flush |=> rpt_valid); // R9

    AST_RPT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rpt_mod) && $stable(rpt_keys)); // R9

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bad_len_cnt == $past(bad_len_cnt))
                 || (bad_len_cnt == ERR_W'($past(bad_len_cnt) + 1'b1))); // R8

    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rpt_valid); // R10
endmodule

bind kbd_poll_seq kbd_poll_chk #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_arg    (req_arg),
    .req_arg_en (req_arg_en),
    .req_rd_len (req_rd_len),
    .rpt_valid  (rpt_valid),
    .rpt_ready  (rpt_ready),
    .rpt_mod    (rpt_mod),
    .rpt_keys   (rpt_keys),
    .bad_len_cnt(bad_len_cnt),
    .flush      (cap_flush),
    .commit     (cap_commit)
);

// File: tb/sim_kbd_poll_seq.sv
`timescale 1ns/1ps
module sim_kbd_poll_seq;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready = 1'b0;
    logic [7:0]  req_op, req_arg;
    logic        req_arg_en;
    logic [3:0]  req_rd_len;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        eng_done = 1'b0, int_evt = 1'b0, poll_tick = 1'b0;
    logic        rpt_valid, rpt_ready = 1'b0;
    logic [7:0]  rpt_mod;
    logic [47:0] rpt_keys;
    logic [7:0]  bad_len_cnt;

    int checks = 0, fails = 0;
    bit mon_on = 0, finished = 0;

    bit          exp_valid = 0;
    logic [7:0]  exp_mod = '0;
    logic [47:0] exp_keys = '0;
    int          exp_cnt = 0;
    logic [7:0]  bq [$];

    always #2.5 clk = ~clk;

    kbd_poll_seq #(.TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_arg(req_arg),
        .req_arg_en(req_arg_en), .req_rd_len(req_rd_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .eng_done(eng_done),
        .int_evt(int_evt), .poll_tick(poll_tick),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_mod(rpt_mod),
        .rpt_keys(rpt_keys), .bad_len_cnt(bad_len_cnt)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle reference comparison of the report side
    always @(posedge clk) begin
        #1;
        if (mon_on && !finished) begin
            chk(rpt_valid == exp_valid, "R9 rpt_valid", 64'(rpt_valid), 64'(exp_valid));
            chk(int'(bad_len_cnt) == exp_cnt, "R8 bad_len_cnt", 64'(bad_len_cnt), 64'(exp_cnt));
            if (exp_valid) begin
                chk(rpt_mod == exp_mod, "R8 rpt_mod", 64'(rpt_mod), 64'(exp_mod));
                chk(rpt_keys == exp_keys, "R8 rpt_keys", 64'(rpt_keys), 64'(exp_keys));
            end
        end
    end

    task automatic run_cmd(input logic [7:0] op, input logic [7:0] arg, input bit aen,
                           input logic [3:0] rd, input string tag, input int hold = 0,
                           input bit mid_int = 0, input bit acc = 0);
        logic [7:0] rb [$];
        int wait_n = 0;
        rb = bq;
        bq = {};
        @(negedge clk);
        while (!req_valid && wait_n < 60) begin
            @(negedge clk);
            wait_n++;
        end
        chk(req_valid, {tag, " request present"}, 64'(req_valid), 64'd1);
        chk(req_op == op, {tag, " opcode"}, 64'(req_op), 64'(op));
        chk(req_arg_en == aen, {tag, " arg_en"}, 64'(req_arg_en), 64'(aen));
        if (aen) chk(req_arg == arg, {tag, " arg"}, 64'(req_arg), 64'(arg));
        chk(req_rd_len == rd, {tag, " rd_len"}, 64'(req_rd_len), 64'(rd));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(req_valid && req_op == op, "R3 held request", 64'(req_op), 64'(op));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (mid_int) begin
            int_evt = 1'b1;
            @(negedge clk);
            int_evt = 1'b0;
        end
        foreach (rb[i]) begin
            rsp_valid = 1'b1;
            rsp_data  = rb[i];
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        eng_done  = 1'b1;
        if (acc) begin
            rpt_ready = 1'b1;
            exp_valid = 0;
        end
        if (op == 8'h27) begin
            if (rb.size() == 9 && rb[0] == 8'd8) begin
                exp_valid = 1;
                exp_mod   = rb[1];
                for (int k = 0; k < 6; k++) exp_keys[8*k +: 8] = rb[k + 3];
            end else if (exp_cnt < 255) begin
                exp_cnt++;
            end
        end
        if (op == 8'h22 && rb.size() > 0 && rb[0] == 8'h16) exp_valid = 0;
        @(negedge clk);
        eng_done  = 1'b0;
        rpt_ready = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        poll_tick = 1'b1;
        @(negedge clk);
        poll_tick = 1'b0;
    endtask

    task automatic pulse_int();
        int_evt = 1'b1;
        @(negedge clk);
        int_evt = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!req_valid, tag, 64'(req_valid), 64'd0);
        end
    endtask

    task automatic poll_status(input logic [7:0] st);
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R4 token");
        @(negedge clk);
        pulse_int();
        bq = {st};
        run_cmd(8'h22, 8'h00, 0, 4'd1, "R5 status");
    endtask

    task automatic read_rpt(input logic [7:0] len, input logic [7:0] seed, input bit acc = 0);
        bq = {len};
        for (int i = 0; i < 8; i++) bq.push_back(seed + 8'(i * 3));
        run_cmd(8'h27, 8'h00, 0, 4'd9, "R7 drain", 0, 0, acc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_valid, "R11 req_valid in reset", 64'(req_valid), 64'd0);
        chk(!rpt_valid, "R11 rpt_valid in reset", 64'(rpt_valid), 64'd0);
        chk(bad_len_cnt == 0, "R11 bad_len_cnt in reset", 64'(bad_len_cnt), 64'd0);
        rst_n = 1'b1;
        mon_on = 1;

        // R2: wrong loopback answer repeats the check; R3: request held while not ready
        bq = {8'h00};
        run_cmd(8'h06, 8'h55, 1, 4'd1, "R1 loopback", 3);
        bq = {8'hAA};
        run_cmd(8'h06, 8'h55, 1, 4'd1, "R2 loopback retry");
        run_cmd(8'h05, 8'h00, 0, 4'd0, "R1 soft reset");
        run_cmd(8'h15, 8'h06, 1, 4'd0, "R1 mode");
        quiet(6, "R4 idle without tick");

        // R4: tick while waiting for interrupt is ignored; R7: NAK leaves everything unchanged
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R4 token");
        quiet(3, "R5 wait for interrupt");
        tick();
        quiet(2, "R4 tick ignored when busy");
        pulse_int();
        bq = {8'h2F};
        run_cmd(8'h22, 8'h00, 0, 4'd1, "R5 status");
        quiet(6, "R7 NAK returns to idle");

        // R8: good report, then bad length discarded
        poll_status(8'h14);
        read_rpt(8'd8, 8'h02);
        poll_status(8'h14);
        read_rpt(8'd6, 8'h40);
        // R9: accept the pending report
        @(negedge clk);
        rpt_ready = 1'b1;
        exp_valid = 0;
        @(negedge clk);
        rpt_ready = 1'b0;
        // R9: overwrite a pending report, then accept in the commit cycle
        poll_status(8'h14);
        read_rpt(8'd8, 8'h10);
        poll_status(8'h14);
        read_rpt(8'd8, 8'h20);
        poll_status(8'h14);
        read_rpt(8'd8, 8'h30, 1);

        // R6: timeout without interrupt
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R4 token");
        quiet(TMO + 3, "R6 timeout no status read");
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R6 token after timeout");
        // R6: interrupt in last cycle of window wins
        repeat (TMO - 1) @(negedge clk);
        pulse_int();
        bq = {8'h2F};
        run_cmd(8'h22, 8'h00, 0, 4'd1, "R6 interrupt at expiry");
        // R6: interrupt one cycle late is ignored
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R4 token");
        repeat (TMO) @(negedge clk);
        pulse_int();
        quiet(5, "R6 late interrupt ignored");

        // R5: interrupt during token transfer; R10: disconnect
        tick();
        run_cmd(8'h45, 8'h19, 1, 4'd0, "R5 token", 0, 1);
        bq = {8'h16};
        run_cmd(8'h22, 8'h00, 0, 4'd1, "R5 status after early interrupt");
        run_cmd(8'h06, 8'h55, 1, 4'd1, "R10 re-init loopback");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule